// File: doc/BRIEF.md
# Parallel Running-Sum Scan Unit

This block takes a packed vector of `N` unsigned integers and returns, for every position, the total of that element and all the elements below it. Position 0 is the first element, so output 0 is a copy of input 0 and the top output is the sum of the whole vector. All running sums are produced together.

The sums come from a tree of adders of logarithmic depth, not from a chain of `N-1` adders. Level `k` of the tree adds to each position the partial sum that sits `2^k` places below it. Because addition is associative, grouping the terms this way gives exactly the same totals as adding them one after another. The tree has `clog2(N)` adder levels.

Each output lane is `W + clog2(N)` bits wide, so no running sum can wrap. The parameter `REGISTERED` chooses how the result leaves the block. When it is 1, the result passes through one register stage with a valid flag. When it is 0, the result is purely combinational and the valid flag passes straight through.

Top module: `prefix_sum_unit`

## Requirements
- R1: Input element k occupies `in_vec[k*W +: W]`. Output sum k occupies `out_vec[k*OW +: OW]`, where `OW = W + clog2(N)`.
- R2: Output sum 0 equals input element 0, zero-extended to `OW` bits.
- R3: Output sum k equals the exact unsigned total of input elements 0 through k. With every element at its maximum, output k is `(k+1)*(2^W-1)` and nothing wraps.
- R4: With inputs 1,2,3,4,5,6,7,8 (element 0 first), the outputs are 1,3,6,10,15,21,28,36.
- R5: The output sums never decrease from lane k-1 to lane k.
- R6: With `REGISTERED=1`, `out_valid` equals the value `in_valid` had one clock earlier. The sums for an input accepted while `in_valid` is high appear on the following clock.
- R7: With `REGISTERED=1`, a clock on which `in_valid` is low leaves `out_vec` unchanged, whatever the input data.
- R8: With `REGISTERED=0`, `out_valid` follows `in_valid`, and `out_vec` shows the sums of the present input in the same cycle.
- R9: With `REGISTERED=1`, reset (active-low `rst_n`) clears `out_valid` and `out_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector qualifier |
| in_vec | input | N*W | Packed input elements, element 0 in the low bits |
| out_valid | output | 1 | Output vector qualifier |
| out_vec | output | N*(W+clog2(N)) | Packed running sums, sum 0 in the low bits |

## Verification
The bench drives all-maximum vectors, so an adder or lane narrower than `W+clog2(N)` shows up as truncated upper sums. It uses vectors with a single non-zero element at one end, so a wrong pairing distance in one tree level either leaves lanes empty or counts the element twice. It also sends invalid cycles carrying changed data: a register that loads on every clock would then replace the held result, and a valid flag taken from the wrong cycle would stay out of step with the data. Random vectors are compared every clock against a serial running total for both output modes.

// File: rtl/psu_pkg.sv
package psu_pkg;
    // Width of one running-sum lane: enough headroom for N maximal elements.
    function automatic int unsigned sum_width(input int unsigned w, input int unsigned n);
        return w + $clog2(n);
    endfunction
endpackage

// File: rtl/psu_level.sv
// One tree level: every lane at or above DIST adds the lane DIST places below.
module psu_level #(
    parameter int unsigned N    = 8,
    parameter int unsigned OW   = 11,
    parameter int unsigned DIST = 1
) (
    input  logic [N*OW-1:0] a,
    output logic [N*OW-1:0] y
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        if (i >= DIST) begin : g_add
            assign y[i*OW +: OW] = a[i*OW +: OW] + a[(i-DIST)*OW +: OW];
        end else begin : g_pass
            assign y[i*OW +: OW] = a[i*OW +: OW];
        end
    end
endmodule

// File: rtl/psu_tree.sv
// Log-depth scan network built from doubling-distance levels.
module psu_tree #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 8
) (
    input  logic [N*W-1:0]                      elems,
    output logic [N*psu_pkg::sum_width(W,N)-1:0] sums
);
    localparam int unsigned OW    = psu_pkg::sum_width(W, N);
    localparam int unsigned LEVELS = $clog2(N);

    logic [N*OW-1:0] stg [0:LEVELS];

    for (genvar i = 0; i < N; i++) begin : g_widen
        assign stg[0][i*OW +: OW] = OW'(elems[i*W +: W]);
    end

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        psu_level #(.N(N), .OW(OW), .DIST(1 << k)) u_level (
            .a (stg[k]),
            .y (stg[k+1])
        );
    end

    assign sums = stg[LEVELS];
endmodule

// File: rtl/psu_out_stage.sv
// Optional result register with valid flag, or a straight bypass.
module psu_out_stage #(
    parameter int unsigned DW         = 88,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] sum_vec,
    output logic          out_valid,
    output logic [DW-1:0] out_vec
);
    if (REGISTERED) begin : g_reg
        typedef struct packed {
            logic          valid;
            logic [DW-1:0] data;
        } stage_t;

        stage_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.data = sum_vec;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign out_valid = st_q.valid;
        assign out_vec   = st_q.data;
    end else begin : g_comb
        logic unused_clocking;
        assign unused_clocking = clk ^ rst_n;
        assign out_valid = in_valid;
        assign out_vec   = sum_vec;
    end
endmodule

// File: rtl/prefix_sum_unit.sv
module prefix_sum_unit #(
    parameter int unsigned N          = 8,
    parameter int unsigned W          = 8,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  logic [N*W-1:0]                       in_vec,
    output logic                                 out_valid,
    output logic [N*psu_pkg::sum_width(W,N)-1:0] out_vec
);
    localparam int unsigned OW = psu_pkg::sum_width(W, N);

    logic [N*OW-1:0] sums;

    psu_tree #(.N(N), .W(W)) u_tree (
        .elems (in_vec),
        .sums  (sums)
    );

    psu_out_stage #(.DW(N*OW), .REGISTERED(REGISTERED)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sum_vec   (sums),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );
endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
    parameter int unsigned N          = 8,
    parameter int unsigned W          = 8,
    parameter bit          REGISTERED = 1'b1
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 in_valid,
    input logic [N*W-1:0]                       in_vec,
    input logic                                 out_valid,
    input logic [N*psu_pkg::sum_width(W,N)-1:0] out_vec
);
    localparam int unsigned OW = psu_pkg::sum_width(W, N);
    localparam longint unsigned MAX_TOTAL = longint'(N) * ((longint'(1) << W) - 1);

    // R3: the top lane never exceeds the largest reachable total
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (longint'(out_vec[(N-1)*OW +: OW]) <= MAX_TOTAL));

    // R5: lanes are non-decreasing
    for (genvar i = 1; i < N; i++) begin : g_mono
        a_r5_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_vec[i*OW +: OW] >= out_vec[(i-1)*OW +: OW]));
    end

    if (REGISTERED) begin : g_reg_chk
        // R6: valid follows the input qualifier one clock later
        a_r6_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        a_r6_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R2: lane 0 carries the element accepted on the previous clock
        a_r2_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_vec[OW-1:0] == OW'($past(in_vec[W-1:0]))));
        // R7: an invalid clock keeps the result
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_vec));
    end else begin : g_comb_chk
        // R8: qualifier passes straight through
        a_r8_valid_pass: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
        // R2: lane 0 mirrors element 0 in the same cycle
        a_r2_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
            out_vec[OW-1:0] == OW'(in_vec[W-1:0]));
    end
endmodule

bind prefix_sum_unit psu_checker #(.N(N), .W(W), .REGISTERED(REGISTERED)) u_psu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/prefix_sum_unit_tb.sv
`timescale 1ns/1ps
module prefix_sum_unit_tb;
    localparam int unsigned N  = 8;
    localparam int unsigned W  = 8;
    localparam int unsigned OW = W + $clog2(N);
    localparam int unsigned DW = N*OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N*W-1:0] in_vec = '0;
    logic          out_valid_r, out_valid_c;
    logic [DW-1:0] out_vec_r, out_vec_c;
    logic [DW-1:0] held = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    prefix_sum_unit #(.N(N), .W(W), .REGISTERED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .out_valid(out_valid_r), .out_vec(out_vec_r));

    prefix_sum_unit #(.N(N), .W(W), .REGISTERED(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .out_valid(out_valid_c), .out_vec(out_vec_c));

    // Serial running total, one element after another
    function automatic logic [DW-1:0] serial_ref(input logic [N*W-1:0] v);
        logic [DW-1:0] r = '0;
        longint unsigned acc = 0;
        for (int i = 0; i < N; i++) begin
            acc += longint'(v[i*W +: W]);
            r[i*OW +: OW] = OW'(acc);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Drive at the falling edge, check combinational now and registered after the edge
    task automatic apply(input logic [N*W-1:0] v, input logic vld, input string req);
        logic [DW-1:0] exp;
        @(negedge clk);
        in_vec   = v;
        in_valid = vld;
        #1;
        exp = serial_ref(v);
        chk(out_valid_c == vld, "R8 valid", DW'(out_valid_c), DW'(vld));
        chk(out_vec_c == exp, {req, " R8 comb sums"}, out_vec_c, exp);
        if (vld) held = exp;
        @(posedge clk);
        #1;
        chk(out_valid_r == vld, "R6 valid", DW'(out_valid_r), DW'(vld));
        chk(out_vec_r == held, {req, vld ? " R6 sums" : " R7 hold"}, out_vec_r, held);
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [N*W-1:0] v;
        logic [DW-1:0]  e;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk(out_valid_r == 1'b0, "R9 valid", DW'(out_valid_r), '0);
        chk(out_vec_r == '0, "R9 data", out_vec_r, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 worked example 1..8
        v = '0;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(i + 1);
        apply(v, 1'b1, "R4");
        for (int i = 0; i < N; i++) begin
            chk(out_vec_r[i*OW +: OW] == OW'((i+1)*(i+2)/2), "R4 lane",
                DW'(out_vec_r[i*OW +: OW]), DW'((i+1)*(i+2)/2));
        end
        // R2 lane 0 equals element 0
        chk(out_vec_r[OW-1:0] == OW'(v[W-1:0]), "R2 lane0",
            DW'(out_vec_r[OW-1:0]), DW'(v[W-1:0]));

        // R3 all-maximum, no wrap
        v = '1;
        apply(v, 1'b1, "R3 allmax");
        for (int i = 0; i < N; i++) begin
            chk(out_vec_r[i*OW +: OW] == OW'((i+1)*((1<<W)-1)), "R3 maxlane",
                DW'(out_vec_r[i*OW +: OW]), DW'((i+1)*((1<<W)-1)));
        end

        // R7 invalid cycles with changed data keep the result
        apply('0, 1'b0, "R7 zeros");
        apply({N*W{1'b1}} ^ {W{1'b1}}, 1'b0, "R7 other");

        // R1 single element at either end
        v = '0; v[W-1:0] = W'(200);
        apply(v, 1'b1, "R1 bottom");
        v = '0; v[(N-1)*W +: W] = W'(77);
        apply(v, 1'b1, "R1 top");
        apply('0, 1'b1, "R3 zeros");

        // Random vectors with occasional invalid cycles
        for (int t = 0; t < 300; t++) begin
            for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
            apply(v, ($urandom % 4) != 0, "R3 random");
            e = out_vec_r;
            for (int i = 1; i < N; i++) begin
                chk(e[i*OW +: OW] >= e[(i-1)*OW +: OW], "R5 monotonic",
                    DW'(e[i*OW +: OW]), DW'(e[(i-1)*OW +: OW]));
            end
        end
        finish_run();
    end
endmodule